// File: doc/BRIEF.md
# XOR Phase-Frequency Discriminator

This block compares a reference square wave with the feedback from a controlled oscillator. It drives a single error bit. A loop filter averages that bit into a tuning signal. Both inputs are asynchronous to the fast system clock. Each passes through a synchronizer, and its rising edges are then extracted.

Close to lock, the error bit is the exclusive-OR of the two synchronized levels, so its duty cycle tracks the phase offset. With equal 50% duty square waves and an offset of d cycles out of a period P (d at most P/2), the bit is high for 2d/P of the time. A quarter-period offset gives the mid-scale point of 50%.

Far from lock, XOR averaging can settle on a harmonic. To prevent that, the block counts rising edges on each input since the last edge on the other one. When one input shows two edges before the other shows any, a flag is raised. The flag takes over the error bit and pins it at the level that drags the oscillator toward the reference rate. The flag drops on the next rising edge of the lagging input, and control then returns to the XOR comparison.

Top module: `phase_freq_discriminator`

## Requirements
- R1: A synchronous active-high `rst` clears both flags, the edge counters and the synchronizers. From the first clock edge after `rst` is sampled high, `osc_fast`, `osc_slow` and `err_out` are 0.
- R2: With both inputs at the same frequency and no flag active, `err_out` equals the XOR of the synchronized inputs. Over whole periods of 16 clocks, its high count is 2d/16 of the cycles for an offset of d = 0, 2, 4 or 8 clocks.
- R3: When the reference shows two rising edges with no oscillator rising edge between them, `osc_slow` becomes 1.
- R4: When the oscillator shows two rising edges with no reference rising edge between them, `osc_fast` becomes 1.
- R5: While `osc_slow` is 1, `err_out` is held at 1 (speed up). While `osc_fast` is 1, `err_out` is held at 0 (slow down).
- R6: An active flag clears on the next rising edge of the lagging input. After that, `err_out` follows the XOR again.
- R7: `osc_fast` and `osc_slow` are never 1 at the same time.
- R8: Rising edges that arrive on both inputs in the same cycle reset both edge counts and raise no flag. An oscillator at twice the reference rate with coincident edges therefore raises no flag.
- R9: In XOR mode, a level change on an input appears on `err_out` at the third clock edge after it is driven, which is SYNC_STAGES+1 edges.
- R10: An oscillator at twice the reference rate with offset edges raises `osc_fast` and never `osc_slow`. At half the reference rate it raises `osc_slow` and never `osc_fast`. At a 4:1 ratio in either direction, the mean of `err_out` lies on the side that corrects the oscillator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both inputs must toggle slower than half its rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference square wave, asynchronous |
| osc_in | input | 1 | Oscillator feedback square wave, asynchronous |
| err_out | output | 1 | Error bit whose mean value is the tuning error |
| osc_fast | output | 1 | Oscillator-too-fast flag; forces `err_out` low |
| osc_slow | output | 1 | Oscillator-too-slow flag; forces `err_out` high |

## Verification
An input driven before clock edge k is captured at edge k and becomes the synchronized level at edge k+1. At edge k+2 it reaches both the XOR output register and the flag registers. A flag override therefore shows on `err_out` one edge later, at k+3. The bench drives inputs on falling edges and samples outputs on the falling edge before it drives. The directed latency test checks `err_out` after exactly two and three rising edges. The flag tests wait at least four edges after the deciding input edge. The duty-cycle checks count `err_out` over a window of whole input periods that opens 64 cycles after reset, so the fixed pipeline delay cancels out of the exact counts.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // Source selected for the error bit
   typedef enum logic [1:0] {
      MODE_XOR        = 2'd0,
      MODE_FORCE_LOW  = 2'd1,
      MODE_FORCE_HIGH = 2'd2
   } pfd_mode_e;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic lvl,
   output logic rise
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] chain;
   logic         last;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[TOP-1:0], async_in};
         last  <= chain[TOP];
      end
   end

   assign lvl  = chain[TOP];
   assign rise = chain[TOP] & ~last;

endmodule

// File: rtl/pfd_freq_tracker.sv
module pfd_freq_tracker #(
   parameter int EDGE_LIMIT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_rise,
   input  logic osc_rise,
   output logic osc_fast,
   output logic osc_slow
);
   localparam int             CW     = $clog2(EDGE_LIMIT + 1);
   localparam logic [CW-1:0]  LIM    = CW'(EDGE_LIMIT);
   localparam logic [CW-1:0]  LIM_M1 = CW'(EDGE_LIMIT - 1);
   localparam logic [CW-1:0]  ONE    = CW'(1);

   logic [CW-1:0] ref_cnt;
   logic [CW-1:0] osc_cnt;
   logic          fast_q;
   logic          slow_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_cnt <= '0;
         osc_cnt <= '0;
         fast_q  <= 1'b0;
         slow_q  <= 1'b0;
      end else begin
         unique case ({ref_rise, osc_rise})
            2'b11: begin
               // coincident edges: neither input leads
               ref_cnt <= '0;
               osc_cnt <= '0;
               fast_q  <= 1'b0;
               slow_q  <= 1'b0;
            end
            2'b10: begin
               osc_cnt <= '0;
               fast_q  <= 1'b0;
               if (ref_cnt >= LIM_M1) slow_q <= 1'b1;
               if (ref_cnt != LIM) ref_cnt <= ref_cnt + ONE;
            end
            2'b01: begin
               ref_cnt <= '0;
               slow_q  <= 1'b0;
               if (osc_cnt >= LIM_M1) fast_q <= 1'b1;
               if (osc_cnt != LIM) osc_cnt <= osc_cnt + ONE;
            end
            default: ;
         endcase
      end
   end

   assign osc_fast = fast_q;
   assign osc_slow = slow_q;

endmodule

// File: rtl/phase_freq_discriminator.sv
module phase_freq_discriminator #(
   parameter int SYNC_STAGES    = 2,
   parameter int EDGE_LIMIT     = 2,
   parameter bit OUT_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_in,
   input  logic osc_in,
   output logic err_out,
   output logic osc_fast,
   output logic osc_slow
);
   import pfd_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (EDGE_LIMIT < 2) begin : g_bad_limit
      $error("EDGE_LIMIT must be at least 2");
   end

   logic      ref_lvl, ref_rise;
   logic      osc_lvl, osc_rise;
   pfd_mode_e mode;
   logic      next_out;

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ref_in),
      .lvl      (ref_lvl),
      .rise     (ref_rise)
   );

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (osc_in),
      .lvl      (osc_lvl),
      .rise     (osc_rise)
   );

   pfd_freq_tracker #(.EDGE_LIMIT(EDGE_LIMIT)) u_track (
      .clk      (clk),
      .rst      (rst),
      .ref_rise (ref_rise),
      .osc_rise (osc_rise),
      .osc_fast (osc_fast),
      .osc_slow (osc_slow)
   );

   always_comb begin
      if (osc_slow)      mode = MODE_FORCE_HIGH;
      else if (osc_fast) mode = MODE_FORCE_LOW;
      else               mode = MODE_XOR;
   end

   always_comb begin
      unique case (mode)
         MODE_FORCE_HIGH: next_out = 1'b1;
         MODE_FORCE_LOW:  next_out = 1'b0;
         default:         next_out = ref_lvl ^ osc_lvl;
      endcase
   end

   if (OUT_REGISTERED) begin : g_out_reg
      logic out_q;
      always_ff @(posedge clk) begin
         if (rst) out_q <= 1'b0;
         else     out_q <= next_out;
      end
      assign err_out = out_q;
   end else begin : g_out_comb
      assign err_out = next_out;
   end

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
   parameter bit OUT_REGISTERED = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic ref_lvl,
   input logic osc_lvl,
   input logic ref_rise,
   input logic osc_rise,
   input logic err_out,
   input logic osc_fast,
   input logic osc_slow
);

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!osc_fast && !osc_slow && !err_out));

   assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      !(osc_fast && osc_slow));

   assert_slow_clears_R6: assert property (@(posedge clk) disable iff (rst)
      (osc_rise && !ref_rise) |=> !osc_slow);

   assert_fast_clears_R6: assert property (@(posedge clk) disable iff (rst)
      (ref_rise && !osc_rise) |=> !osc_fast);

   assert_coincident_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
      (ref_rise && osc_rise) |=> (!osc_fast && !osc_slow));

   if (OUT_REGISTERED) begin : g_reg_chk
      assert_slow_forces_high_R5: assert property (@(posedge clk) disable iff (rst)
         osc_slow |=> err_out);

      assert_fast_forces_low_R5: assert property (@(posedge clk) disable iff (rst)
         osc_fast |=> !err_out);

      assert_xor_mode_R2: assert property (@(posedge clk) disable iff (rst)
         (!osc_fast && !osc_slow) |=> (err_out == $past(ref_lvl ^ osc_lvl)));
   end else begin : g_comb_chk
      assert_slow_forces_high_R5: assert property (@(posedge clk) disable iff (rst)
         osc_slow |-> err_out);

      assert_fast_forces_low_R5: assert property (@(posedge clk) disable iff (rst)
         osc_fast |-> !err_out);
   end

endmodule

bind phase_freq_discriminator pfd_checker #(.OUT_REGISTERED(OUT_REGISTERED)) u_pfd_chk (
   .clk      (clk),
   .rst      (rst),
   .ref_lvl  (ref_lvl),
   .osc_lvl  (osc_lvl),
   .ref_rise (ref_rise),
   .osc_rise (osc_rise),
   .err_out  (err_out),
   .osc_fast (osc_fast),
   .osc_slow (osc_slow)
);

// File: tb/test_phase_freq_discriminator.sv
module test_phase_freq_discriminator;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_in = 1'b0;
   logic osc_in = 1'b0;
   logic err_out, osc_fast, osc_slow;

   int checks = 0;
   int failures = 0;
   int both_flags = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   phase_freq_discriminator i_phase_freq_discriminator (
      .clk      (clk),
      .rst      (rst),
      .ref_in   (ref_in),
      .osc_in   (osc_in),
      .err_out  (err_out),
      .osc_fast (osc_fast),
      .osc_slow (osc_slow)
   );

   // field layout: ref_half[37:30] osc_half[29:22] osc_delay[21:14]
   // ones[13:4] cmp[3:2] (0 exact,1 below half,2 above half,3 none)
   // flag[1:0] (0 none,1 fast,2 slow)
   localparam int NVEC   = 9;
   localparam int SETTLE = 64;
   localparam int WIN    = 128;
   localparam logic [37:0] VEC [NVEC] = '{
      {8'd8,  8'd8,  8'd0, 10'd0,   2'd0, 2'd0},
      {8'd8,  8'd8,  8'd2, 10'd32,  2'd0, 2'd0},
      {8'd8,  8'd8,  8'd4, 10'd64,  2'd0, 2'd0},
      {8'd8,  8'd8,  8'd8, 10'd128, 2'd0, 2'd0},
      {8'd8,  8'd4,  8'd0, 10'd64,  2'd0, 2'd0},
      {8'd8,  8'd4,  8'd3, 10'd0,   2'd1, 2'd1},
      {8'd4,  8'd8,  8'd3, 10'd0,   2'd3, 2'd2},
      {8'd4,  8'd16, 8'd5, 10'd0,   2'd2, 2'd2},
      {8'd16, 8'd4,  8'd5, 10'd0,   2'd1, 2'd1}
   };

   always @(negedge clk) if (!rst && osc_fast && osc_slow) both_flags++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply_reset();
      rst = 1'b1; ref_in = 1'b0; osc_in = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic pulse(input bit on_ref);
      @(negedge clk);
      if (on_ref) ref_in = 1'b1; else osc_in = 1'b1;
      repeat (3) @(negedge clk);
      if (on_ref) ref_in = 1'b0; else osc_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      // R1: outputs during reset
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(err_out == 1'b0, "R1 err_out in reset", int'(err_out), 0);
      check(osc_fast == 1'b0 && osc_slow == 1'b0, "R1 flags in reset",
            int'({osc_fast, osc_slow}), 0);
      rst = 1'b0;

      // vector table: R2, R8, R10, R5
      for (int v = 0; v < NVEC; v++) begin
         int rh, oh, od, exp_ones, cmp, flg, ones;
         bit seen_fast, seen_slow;
         rh = int'(VEC[v][37:30]); oh = int'(VEC[v][29:22]);
         od = int'(VEC[v][21:14]); exp_ones = int'(VEC[v][13:4]);
         cmp = int'(VEC[v][3:2]);  flg = int'(VEC[v][1:0]);
         ones = 0; seen_fast = 1'b0; seen_slow = 1'b0;
         apply_reset();
         for (int t = 0; t < SETTLE + WIN; t++) begin
            @(negedge clk);
            if (t >= SETTLE) begin
               ones += int'(err_out);
               seen_fast |= osc_fast;
               seen_slow |= osc_slow;
            end
            ref_in = ((t % (2 * rh)) < rh);
            osc_in = (((t + 16 * oh - od) % (2 * oh)) < oh);
         end
         case (cmp)
            0: check(ones == exp_ones, "R2/R8 duty count", ones, exp_ones);
            1: check(ones < WIN / 2, "R5/R10 mean below half", ones, WIN / 2);
            2: check(ones > WIN / 2, "R5/R10 mean above half", ones, WIN / 2);
            default: ;
         endcase
         check(seen_fast == (flg == 1), "R4/R8/R10 fast flag seen", int'(seen_fast), int'(flg == 1));
         check(seen_slow == (flg == 2), "R3/R8/R10 slow flag seen", int'(seen_slow), int'(flg == 2));
      end

      // R9: latency of a level change in XOR mode
      apply_reset();
      @(negedge clk);
      ref_in = 1'b1;
      repeat (2) @(negedge clk);
      check(err_out == 1'b0, "R9 err_out after two edges", int'(err_out), 0);
      @(negedge clk);
      check(err_out == 1'b1, "R9 err_out after three edges", int'(err_out), 1);

      // R3, R5, R6: two reference edges, then oscillator edge
      apply_reset();
      pulse(1'b1);
      pulse(1'b1);
      check(osc_slow == 1'b1, "R3 slow after two ref edges", int'(osc_slow), 1);
      check(osc_fast == 1'b0, "R7 fast stays low", int'(osc_fast), 0);
      check(err_out == 1'b1, "R5 slow forces high", int'(err_out), 1);
      pulse(1'b0);
      check(osc_slow == 1'b0, "R6 slow clears on osc edge", int'(osc_slow), 0);
      check(err_out == 1'b0, "R6 back to XOR", int'(err_out), 0);

      // R4, R5, R6: two oscillator edges, osc held high
      apply_reset();
      pulse(1'b0);
      @(negedge clk);
      osc_in = 1'b1;
      repeat (5) @(negedge clk);
      check(osc_fast == 1'b1, "R4 fast after two osc edges", int'(osc_fast), 1);
      check(err_out == 1'b0, "R5 fast forces low over XOR", int'(err_out), 0);
      ref_in = 1'b1;
      repeat (3) @(negedge clk);
      osc_in = 1'b0;
      repeat (5) @(negedge clk);
      check(osc_fast == 1'b0, "R6 fast clears on ref edge", int'(osc_fast), 0);
      check(err_out == 1'b1, "R6 XOR after clear", int'(err_out), 1);

      // R1: reset while a flag is active
      apply_reset();
      pulse(1'b1);
      pulse(1'b1);
      rst = 1'b1;
      @(negedge clk);
      check(osc_slow == 1'b0 && err_out == 1'b0, "R1 reset clears active flag",
            int'({osc_slow, err_out}), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      check(both_flags == 0, "R7 flags never both high", both_flags, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule